// File: doc/BRIEF.md
# Conditional Branch Resolver with Delay-Slot Annul

This block decides where control goes after a conditional integer branch in a pipeline that has one delay slot. Each strobed input presents the 32-bit instruction word, the address of that instruction and the four condition flags (negative, zero, overflow, carry). The block recognises the branch format and evaluates one of sixteen condition tests against the flags. It forms the branch target from a signed word displacement. It then reports whether the branch is taken, whether the instruction in the delay slot runs or is skipped, and which address execution resumes at once the branch and its slot are done.

The annul bit does not act the same way in every case. On an untaken branch it squashes the delay slot. On a taken conditional branch it has no effect. On branch-always it squashes the slot and sends control straight to the target. Two saturating event counters record how many branches were taken and how many delay slots were annulled. All results are registered and appear one cycle after the strobe.

Top module: `branch_resolve`

## Requirements
- R1: An instruction is treated as a branch only when bits 31:30 are 00 and bits 24:22 are 010. Any other word gives is_branch=0, taken=0, slot_exec=0, slot_annul=0 and resume_pc = pc+4, and it leaves both counters unchanged.
- R2: The condition code is bits 28:25. Codes 0 to 8 test, in order: never, Z, Z|(N^V), N^V, C|Z, C, N, V, always.
- R3: Codes 9 to 15 are the inverses of codes 1 to 7 in the same order (for example, 9 is !Z and 15 is !V).
- R4: target = pc + 4 * sign-extend(bits 21:0), with bit 21 as the sign and the sum taken modulo 2^32. It is computed for every branch, whether or not the branch is taken.
- R5: For an untaken branch with annul bit 29 clear: slot_exec=1, slot_annul=0, resume_pc = pc+8.
- R6: For an untaken branch with annul bit 29 set: slot_exec=0, slot_annul=1, resume_pc = pc+8, and the annulled counter increments.
- R7: For a taken branch other than always-with-annul: slot_exec=1, slot_annul=0 and resume_pc = target, whatever the value of the annul bit.
- R8: For branch-always (code 8) with annul set: taken=1, slot_exec=0, slot_annul=1 and resume_pc = target, and both counters increment.
- R9: Outputs are registered. out_valid is high exactly one cycle after each in_valid cycle. Without a strobe, out_valid is low and the result outputs hold their values.
- R10: taken_count increments for each strobed taken branch and annul_count for each strobed annulled slot. Both are CNT_W bits wide and stop at their all-ones value.
- R11: While rst_n is low, out_valid, taken_count and annul_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: instr, pc and flags are valid |
| instr | input | 32 | Instruction word |
| pc | input | ADDR_W | Address of the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | Registered result valid |
| is_branch | output | 1 | Word matched the branch format |
| taken | output | 1 | Branch condition true |
| slot_exec | output | 1 | Delay-slot instruction executes |
| slot_annul | output | 1 | Delay-slot instruction is skipped |
| target | output | ADDR_W | Branch target address |
| resume_pc | output | ADDR_W | Address reached after the branch and its slot |
| taken_count | output | CNT_W | Saturating count of taken branches |
| annul_count | output | CNT_W | Saturating count of annulled slots |

## Verification
The assertions that refer back to the previous cycle's pc assume pc is defined at every strobe. They also assume in_valid is 0 or 1 and never unknown. The stimulus drives every input on the falling edge from a known value from time zero, and it always presents a defined pc with each strobe. Every one of the sixteen condition codes is swept against all sixteen flag combinations with the annul bit toggled. Extreme displacements and address wraparound, non-branch words, idle gaps and a mid-run reset are added on top of the sweep. A narrow counter width is used so that saturation is reached.

// File: rtl/brres_pkg.sv
package brres_pkg;
   localparam int INSTR_W   = 32;
   localparam int OP_HI     = 31;
   localparam int OP_LO     = 30;
   localparam int ANNUL_POS = 29;
   localparam int COND_HI   = 28;
   localparam int COND_LO   = 25;
   localparam int FMT_HI    = 24;
   localparam int FMT_LO    = 22;
   localparam int DISP_HI   = 21;

   localparam logic [1:0] BR_OP      = 2'b00;
   localparam logic [2:0] BR_FMT     = 3'b010;
   localparam logic [3:0] COND_ALWAYS = 4'b1000;

   typedef struct packed {
      logic is_br;
      logic taken;
      logic exec;
      logic annul;
   } br_decision_t;
endpackage

// File: rtl/brres_cond_eval.sv
module brres_cond_eval (
   input  logic [3:0] code,
   input  logic       n,
   input  logic       z,
   input  logic       v,
   input  logic       c,
   output logic       hit
);
   logic base;

   always_comb begin
      unique case (code[2:0])
         3'd0: base = 1'b0;
         3'd1: base = z;
         3'd2: base = z | (n ^ v);
         3'd3: base = n ^ v;
         3'd4: base = c | z;
         3'd5: base = c;
         3'd6: base = n;
         default: base = v;
      endcase
      // upper half of the code space inverts the lower half
      hit = base ^ code[3];
   end
endmodule

// File: rtl/brres_target_gen.sv
module brres_target_gen #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 22
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target
);
   localparam int EXT_W = DISP_W + 2;

   logic [ADDR_W-1:0] offset;

   if (DISP_W < 2) begin : g_bad_disp
      $error("brres_target_gen: DISP_W must be at least 2");
   end

   if (ADDR_W > EXT_W) begin : g_sext
      assign offset = {{(ADDR_W-EXT_W){disp[DISP_W-1]}}, disp, 2'b00};
   end else if (ADDR_W == EXT_W) begin : g_exact
      assign offset = {disp, 2'b00};
   end else begin : g_trunc
      logic [EXT_W-1:0] wide;
      assign wide   = {disp, 2'b00};
      assign offset = wide[ADDR_W-1:0];
   end

   assign target = pc + offset;
endmodule

// File: rtl/brres_sat_counter.sv
module brres_sat_counter #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("brres_sat_counter: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       cnt_q <= '0;
         else if (inc && cnt_q != MAXV)    cnt_q <= cnt_q + 1'b1;
      end

      p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         count == MAXV |=> count == MAXV);
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt_q <= '0;
         else if (inc) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import brres_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       instr,
   input  logic [ADDR_W-1:0] pc,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_v,
   input  logic              flag_c,
   output logic              out_valid,
   output logic              is_branch,
   output logic              taken,
   output logic              slot_exec,
   output logic              slot_annul,
   output logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] resume_pc,
   output logic [CNT_W-1:0]  taken_count,
   output logic [CNT_W-1:0]  annul_count
);
   localparam int DISP_W = DISP_HI + 1;
   localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(8);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("branch_resolve: ADDR_W must be at least 8");
   end

   // ---------------- field split ----------------
   logic [3:0]        cond;
   logic              annul_bit;
   logic              fmt_match;
   logic              cond_hit;
   logic [ADDR_W-1:0] tgt_c;
   logic [ADDR_W-1:0] resume_c;
   br_decision_t      dec;

   assign cond      = instr[COND_HI:COND_LO];
   assign annul_bit = instr[ANNUL_POS];
   assign fmt_match = (instr[OP_HI:OP_LO] == BR_OP) && (instr[FMT_HI:FMT_LO] == BR_FMT);

   brres_cond_eval u_cond (
      .code (cond),
      .n    (flag_n),
      .z    (flag_z),
      .v    (flag_v),
      .c    (flag_c),
      .hit  (cond_hit)
   );

   brres_target_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
      .pc     (pc),
      .disp   (instr[DISP_HI:0]),
      .target (tgt_c)
   );

   // ---------------- decision ----------------
   always_comb begin
      dec.is_br = fmt_match;
      dec.taken = fmt_match & cond_hit;
      // annul squashes an untaken slot, or the slot of branch-always
      dec.annul = fmt_match & annul_bit & (~cond_hit | (cond == COND_ALWAYS));
      dec.exec  = fmt_match & ~dec.annul;
      if (!fmt_match)     resume_c = pc + STEP1;
      else if (dec.taken) resume_c = tgt_c;
      else                resume_c = pc + STEP2;
   end

   // ---------------- output registers ----------------
   br_decision_t      dec_q;
   logic              vld_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [ADDR_W-1:0] resume_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         dec_q    <= '0;
         tgt_q    <= '0;
         resume_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            dec_q    <= dec;
            tgt_q    <= tgt_c;
            resume_q <= resume_c;
         end
      end
   end

   assign out_valid  = vld_q;
   assign is_branch  = dec_q.is_br;
   assign taken      = dec_q.taken;
   assign slot_exec  = dec_q.exec;
   assign slot_annul = dec_q.annul;
   assign target     = tgt_q;
   assign resume_pc  = resume_q;

   // ---------------- event counters ----------------
   brres_sat_counter #(.W(CNT_W), .SATURATE(1'b1)) u_taken_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (in_valid & dec.taken),
      .count (taken_count)
   );

   brres_sat_counter #(.W(CNT_W), .SATURATE(1'b1)) u_annul_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (in_valid & dec.annul),
      .count (annul_count)
   );

   // ---------------- assertions ----------------
   p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(resume_pc) && $stable(target)));

   p_nonbr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !is_branch) |-> (!taken && !slot_exec && !slot_annul));

   p_slot_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && is_branch) |-> ($countones({slot_exec, slot_annul}) == 1));

   p_untaken_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && is_branch && !taken) |-> (resume_pc == $past(pc) + STEP2));

   p_taken_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && taken) |-> (resume_pc == target));

   p_annul_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && taken && slot_annul) |-> (resume_pc == target && !slot_exec));

   p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_count == $past(taken_count)) || (taken_count == $past(taken_count) + 1'b1));
endmodule

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 4;
   localparam int CMAX       = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] pc = '0;
   logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
   logic        out_valid, is_branch, taken, slot_exec, slot_annul;
   logic [31:0] target, resume_pc;
   logic [CW-1:0] taken_count, annul_count;

   int total = 0;
   int bad   = 0;
   int ref_tcnt = 0;
   int ref_acnt = 0;

   branch_resolve #(.ADDR_W(32), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
      .out_valid(out_valid), .is_branch(is_branch), .taken(taken),
      .slot_exec(slot_exec), .slot_annul(slot_annul), .target(target),
      .resume_pc(resume_pc), .taken_count(taken_count), .annul_count(annul_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit cond_true(int code, bit n, bit z, bit v, bit c);
      case (code)
         0: return 0;
         1: return z;
         2: return z || (n != v);
         3: return n != v;
         4: return c || z;
         5: return c;
         6: return n;
         7: return v;
         8: return 1;
         9: return !z;
         10: return !(z || (n != v));
         11: return n == v;
         12: return !(c || z);
         13: return !c;
         14: return !n;
         default: return !v;
      endcase
   endfunction

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // drive one strobe (caller is at a falling edge), check at the next falling edge
   task automatic apply(logic [31:0] w, logic [31:0] p, logic [3:0] nzvc);
      bit br, t, a, ex, an;
      int code, d;
      logic [31:0] tgt, res;
      string tag;
      instr = w; pc = p;
      {flag_n, flag_z, flag_v, flag_c} = nzvc;
      in_valid = 1'b1;
      br   = (w[31:30] == 2'b00) && (w[24:22] == 3'b010);
      code = int'(w[28:25]);
      a    = w[29];
      t    = br && cond_true(code, nzvc[3], nzvc[2], nzvc[1], nzvc[0]);
      d    = w[21] ? int'(w[21:0]) - 4194304 : int'(w[21:0]);
      tgt  = p + 32'(d * 4);
      if (!br)                 begin tag = "R1"; ex = 0; an = 0; res = p + 4; end
      else if (!t && !a)       begin tag = "R5"; ex = 1; an = 0; res = p + 8; end
      else if (!t && a)        begin tag = "R6"; ex = 0; an = 1; res = p + 8; end
      else if (code == 8 && a) begin tag = "R8"; ex = 0; an = 1; res = tgt; end
      else                     begin tag = "R7"; ex = 1; an = 0; res = tgt; end
      if (t  && ref_tcnt < CMAX) ref_tcnt++;
      if (an && ref_acnt < CMAX) ref_acnt++;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9", "out_valid", 32'(out_valid), 32'd1);
      chk("R1", "is_branch", 32'(is_branch), 32'(br));
      chk(code < 8 ? "R2" : "R3", "taken", 32'(taken), 32'(t));
      chk(tag, "slot_exec", 32'(slot_exec), 32'(ex));
      chk(tag, "slot_annul", 32'(slot_annul), 32'(an));
      chk(tag, "resume_pc", resume_pc, res);
      if (br) chk("R4", "target", target, tgt);
      chk("R10", "taken_count", 32'(taken_count), 32'(ref_tcnt));
      chk("R10", "annul_count", 32'(annul_count), 32'(ref_acnt));
   endtask

   task automatic idle(int n);
      logic [31:0] held;
      held = resume_pc;
      in_valid = 1'b0;
      instr = 32'hFFFF_FFFF;
      pc    = 32'h1234_5678;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R9", "idle out_valid", 32'(out_valid), 32'd0);
         chk("R9", "idle resume_pc", resume_pc, held);
      end
   endtask

   function automatic logic [31:0] mk_br(bit a, logic [3:0] code, logic [21:0] disp);
      return {2'b00, a, code, 3'b010, disp};
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      chk("R11", "reset out_valid", 32'(out_valid), 32'd0);
      chk("R11", "reset taken_count", 32'(taken_count), 32'd0);
      chk("R11", "reset annul_count", 32'(annul_count), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // full sweep: every code against every flag combination, annul toggled
      for (int code = 0; code < 16; code++) begin
         for (int f = 0; f < 16; f++) begin
            apply(mk_br(bit'((code + f) % 2), 4'(code), 22'($urandom)),
                  {$urandom} & 32'hFFFF_FFFC, 4'(f));
         end
      end

      // R4 displacement corners
      apply(mk_br(1'b0, 4'd8, 22'h1F_FFFF), 32'h0000_1000, 4'h0);
      apply(mk_br(1'b0, 4'd8, 22'h20_0000), 32'h8000_0000, 4'h0);
      apply(mk_br(1'b0, 4'd8, 22'h3F_FFFF), 32'h0000_0000, 4'h0);
      apply(mk_br(1'b0, 4'd8, 22'h00_0001), 32'hFFFF_FFFC, 4'h0);

      // R8 / R6 explicit: always-annul and never-annul
      apply(mk_br(1'b1, 4'd8, 22'h00_0010), 32'h0000_2000, 4'hF);
      apply(mk_br(1'b1, 4'd0, 22'h00_0010), 32'h0000_2000, 4'hF);
      // R7: taken conditional with annul set still runs its slot
      apply(mk_br(1'b1, 4'd1, 22'h00_0020), 32'h0000_3000, 4'b0100);

      // R1: words outside the branch format
      apply({2'b01, 30'h0000_0040}, 32'h0000_4000, 4'hF);
      apply({2'b00, 1'b1, 4'd8, 3'b100, 22'h1}, 32'h0000_4004, 4'hF);
      apply({2'b10, 1'b0, 4'd8, 3'b010, 22'h1}, 32'h0000_4008, 4'hF);
      apply({2'b11, 1'b1, 4'd0, 3'b010, 22'h1}, 32'hFFFF_FFFC, 4'h0);

      idle(3);

      // R11: reset mid-run clears counters
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11", "mid reset out_valid", 32'(out_valid), 32'd0);
      chk("R11", "mid reset taken_count", 32'(taken_count), 32'd0);
      chk("R11", "mid reset annul_count", 32'(annul_count), 32'd0);
      ref_tcnt = 0; ref_acnt = 0;
      rst_n = 1'b1;
      @(negedge clk);
      apply(mk_br(1'b1, 4'd8, 22'h00_0004), 32'h0000_0100, 4'h0);
      apply(mk_br(1'b1, 4'd9, 22'h00_0004), 32'h0000_0200, 4'b0100);

      finish_run();
   end
endmodule